// File: doc/BRIEF.md
# Operand Fetch and Effective Address Unit

This unit runs after the opcode decoder of a small 8-bit processor with a 16-bit address space. A one-cycle start strobe hands it the addressing mode, the operand size, an index-register select and a flag that says a prefix byte came before the opcode. It also receives the address that follows the last opcode byte and the two index register values. It then reads the operand bytes one at a time over a simple synchronous byte-read handshake. The result is either the immediate argument or a 16-bit effective address, together with the total instruction length in bytes.

The controller is a four-state machine:
- `S_IDLE` is entered from reset.
- `S_FIRST` fetches the first operand byte.
- `S_SECOND` fetches the low byte of a two-byte operand.
- `S_DONE` holds the results.

Its transitions are:
- idle→first on an accepted start.
- first→second on a handshake when two bytes are needed.
- first→done on a handshake when one byte is needed.
- second→done on a handshake.
- done→first on a new accepted start.
- any state→idle on reset.

A start is accepted only in `S_IDLE` or `S_DONE`.

Top module: `opfetch_agu`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `done` and `rd_req` low from the next cycle on, whatever was in progress.
- R2: A `start` high at an edge while the unit is idle or done is accepted, and `rd_req` rises in the next cycle with `rd_addr` equal to `next_pc`. A `start` seen while fetching is ignored and leaves the operation in progress unchanged.
- R3: A byte is consumed at each edge where `rd_req` and `rd_ack` are both high. After each consumed byte `rd_addr` advances by one, wrapping at 0xFFFF. While `rd_ack` is low, `rd_req` and `rd_addr` hold. The number of bytes consumed equals the operand byte count.
- R4: Mode code 0 (immediate) reads 1 byte when `wide`=0 or 2 bytes when `wide`=1, high byte first. An 8-bit argument appears zero-extended in `imm_data`, with `is_addr`=0 and `eff_addr`=0.
- R5: Mode code 1 (direct) reads one byte. `eff_addr` is 0x00 in bits 15:8 and that byte in bits 7:0, and `is_addr`=1.
- R6: Mode code 2 (extended) reads two bytes, high byte first, and they form `eff_addr`, with `is_addr`=1.
- R7: Mode code 3 (indexed) reads one offset byte. `eff_addr` is (index + zero-extended offset) mod 65536, where the index is `ix` when `idx_sel`=0 or `iy` when `idx_sel`=1, sampled at the accepted start.
- R8: `inst_len` = 1 + `has_pre` + operand bytes. That gives immediate 2 to 4, direct 2 or 3, extended 3 or 4, and indexed 2 or 3.
- R9: `done` rises in the cycle after the last byte's handshake. With `rd_ack` held high this is N cycles after the cycle in which the start was accepted, where N is the operand byte count. `done` then stays high with all results stable until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operand fetch |
| mode | input | 2 | Addressing mode: 0 immediate, 1 direct, 2 extended, 3 indexed |
| wide | input | 1 | Immediate operand is 16 bits |
| idx_sel | input | 1 | Index select: 0 X, 1 Y |
| has_pre | input | 1 | A prefix byte precedes the opcode |
| next_pc | input | 16 | Address after the last opcode byte |
| ix | input | 16 | Index register X |
| iy | input | 16 | Index register Y |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 16 | Byte read address |
| rd_ack | input | 1 | Read accepted; `rd_data` valid |
| rd_data | input | 8 | Byte read data |
| done | output | 1 | Results valid |
| is_addr | output | 1 | 1: `eff_addr` valid, 0: `imm_data` valid |
| imm_data | output | 16 | Immediate argument |
| eff_addr | output | 16 | Effective address |
| inst_len | output | 3 | Instruction length in bytes |

## Verification
The first read request is due one cycle after the accepted start. Each further byte follows the cycle after its predecessor's handshake, and `done` is due one cycle after the final handshake. That makes a one-byte operand finish one cycle and a two-byte operand two cycles after the start edge when `rd_ack` stays high. The bench drives inputs and samples outputs on falling edges. It counts those edges from the start and compares the count with the operand byte count. It records `rd_addr` at each sampled handshake, so address order and stalls are checked cycle by cycle. Results and their stability are read only once `done` is seen.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;
    typedef enum logic [1:0] {
        AM_IMM = 2'd0,
        AM_DIR = 2'd1,
        AM_EXT = 2'd2,
        AM_IDX = 2'd3
    } amode_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FIRST  = 2'd1,
        S_SECOND = 2'd2,
        S_DONE   = 2'd3
    } fstate_t;

    // number of bytes that follow the opcode for a given mode
    function automatic logic [1:0] operand_bytes(amode_t m, logic wide);
        unique case (m)
            AM_IMM:  operand_bytes = wide ? 2'd2 : 2'd1;
            AM_EXT:  operand_bytes = 2'd2;
            default: operand_bytes = 2'd1;
        endcase
    endfunction
endpackage

// File: rtl/opfetch_fsm.sv
module opfetch_fsm
    import opfetch_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    ack,
    input  logic    two_bytes,
    output fstate_t state,
    output logic    accept,
    output logic    last_beat
);
    fstate_t state_d;

    assign accept    = start && (state == S_IDLE || state == S_DONE);
    assign last_beat = ack && ((state == S_FIRST && !two_bytes) || state == S_SECOND);

    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:   if (accept) state_d = S_FIRST;
            S_FIRST:  if (ack) state_d = two_bytes ? S_SECOND : S_DONE;
            S_SECOND: if (ack) state_d = S_DONE;
            S_DONE:   if (accept) state_d = S_FIRST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_d;
    end

    // R2: a start while fetching does not restart the fetch
    a_r2_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (state == S_FIRST && start && !ack) |=> state == S_FIRST);
    // R3: a stalled second beat waits
    a_r3_second_waits: assert property (@(posedge clk) disable iff (rst)
        (state == S_SECOND && !ack) |=> state == S_SECOND);
endmodule

// File: rtl/opfetch_ea.sv
module opfetch_ea
    import opfetch_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  amode_t          mode,
    input  logic [AW-1:0]   word,
    input  logic [AW-1:0]   index_val,
    output logic [AW-1:0]   imm,
    output logic [AW-1:0]   ea,
    output logic            is_addr
);
    always_comb begin
        imm     = '0;
        ea      = '0;
        is_addr = 1'b1;
        unique case (mode)
            AM_IMM: begin
                imm     = word;
                is_addr = 1'b0;
            end
            AM_DIR:  ea = {{DW{1'b0}}, word[DW-1:0]};
            AM_EXT:  ea = word;
            AM_IDX:  ea = index_val + {{DW{1'b0}}, word[DW-1:0]};
        endcase
    end
endmodule

// File: rtl/opfetch_len.sv
module opfetch_len
    import opfetch_pkg::*;
#(
    parameter int LW = 3
) (
    input  amode_t        mode,
    input  logic          wide,
    input  logic          has_pre,
    output logic [LW-1:0] len
);
    always_comb begin
        len = LW'(1) + LW'(has_pre) + LW'(operand_bytes(mode, wide));
    end
endmodule

// File: rtl/opfetch_agu.sv
module opfetch_agu
    import opfetch_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 3,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic          wide,
    input  logic          idx_sel,
    input  logic          has_pre,
    input  logic [AW-1:0] next_pc,
    input  logic [AW-1:0] ix,
    input  logic [AW-1:0] iy,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          done,
    output logic          is_addr,
    output logic [AW-1:0] imm_data,
    output logic [AW-1:0] eff_addr,
    output logic [LW-1:0] inst_len
);
    fstate_t       state;
    logic          accept, last_beat, two_bytes, beat;
    amode_t        mode_q;
    logic          wide_q, pre_q;
    logic [AW-1:0] index_q, fetch_addr;
    logic [DW-1:0] hi_q;
    logic [AW-1:0] word, imm_c, ea_c;
    logic          is_addr_c;
    logic [AW-1:0] imm_q, ea_q;
    logic          is_addr_q;

    assign two_bytes = (operand_bytes(mode_q, wide_q) == 2'd2);
    assign beat      = rd_req && rd_ack;
    assign word      = (state == S_SECOND) ? {hi_q, rd_data} : {{DW{1'b0}}, rd_data};

    opfetch_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .ack(rd_ack), .two_bytes(two_bytes),
        .state(state), .accept(accept), .last_beat(last_beat)
    );

    opfetch_ea #(.DW(DW)) u_ea (
        .mode(mode_q), .word(word), .index_val(index_q),
        .imm(imm_c), .ea(ea_c), .is_addr(is_addr_c)
    );

    opfetch_len #(.LW(LW)) u_len (
        .mode(mode_q), .wide(wide_q), .has_pre(pre_q), .len(inst_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= AM_IMM;
            wide_q     <= 1'b0;
            pre_q      <= 1'b0;
            index_q    <= '0;
            fetch_addr <= '0;
            hi_q       <= '0;
            imm_q      <= '0;
            ea_q       <= '0;
            is_addr_q  <= 1'b0;
        end else begin
            if (accept) begin
                mode_q     <= amode_t'(mode);
                wide_q     <= wide;
                pre_q      <= has_pre;
                index_q    <= idx_sel ? iy : ix;
                fetch_addr <= next_pc;
            end else if (beat) begin
                fetch_addr <= fetch_addr + AW'(1);
            end
            if (state == S_FIRST && rd_ack) hi_q <= rd_data;
            if (last_beat) begin
                imm_q     <= imm_c;
                ea_q      <= ea_c;
                is_addr_q <= is_addr_c;
            end
        end
    end

    always_comb begin
        rd_req   = (state == S_FIRST) || (state == S_SECOND);
        rd_addr  = fetch_addr;
        done     = (state == S_DONE);
        is_addr  = is_addr_q;
        imm_data = imm_q;
        eff_addr = ea_q;
    end

    // R1: reset clears the handshake and done
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!done && !rd_req));
    // R3: a stalled request holds its address
    a_r3_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && rd_addr == $past(rd_addr)));
    // R3: consecutive beats read consecutive addresses
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (beat && !last_beat) |=> rd_addr == $past(rd_addr) + AW'(1));
    // R9: results stay put while done and no new start
    a_r9_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(eff_addr) && $stable(imm_data)
                              && $stable(inst_len) && $stable(is_addr)));
    // R5: direct addresses lie in the first page
    a_r5_direct_page: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q == AM_DIR) |-> eff_addr[AW-1:DW] == '0);
    // R8: length range
    a_r8_len_range: assert property (@(posedge clk) disable iff (rst)
        done |-> (inst_len >= LW'(2) && inst_len <= LW'(4)));
    // R9: never requesting while done
    a_r9_no_req_when_done: assert property (@(posedge clk) disable iff (rst)
        !(done && rd_req));
endmodule

// File: tb/test_opfetch_agu.sv
`timescale 1ns/1ps
module test_opfetch_agu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        wide = 1'b0, idx_sel = 1'b0, has_pre = 1'b0;
    logic [15:0] next_pc = '0, ix = '0, iy = '0;
    logic        rd_req, rd_ack = 1'b1, stall_en = 1'b0;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data;
    logic        done, is_addr;
    logic [15:0] imm_data, eff_addr;
    logic [2:0]  inst_len;
    int          n_checks = 0, n_fail = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mb(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    assign rd_data = mb(rd_addr);

    always @(posedge clk) rd_ack <= stall_en ? ~rd_ack : 1'b1;

    opfetch_agu i_opfetch_agu (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .wide(wide),
        .idx_sel(idx_sel), .has_pre(has_pre), .next_pc(next_pc), .ix(ix), .iy(iy),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .done(done), .is_addr(is_addr), .imm_data(imm_data), .eff_addr(eff_addr),
        .inst_len(inst_len)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(string tag, logic [1:0] m, logic w, logic s, logic p,
                          logic [15:0] pc, logic [15:0] x, logic [15:0] y,
                          logic stl, logic poke);
        int nb, beats, n;
        logic [7:0]  hi, lo;
        logic [15:0] word, e_imm, e_ea;
        nb = (m == 2'd0) ? (w ? 2 : 1) : ((m == 2'd2) ? 2 : 1);
        hi = mb(pc);
        lo = mb(pc + 16'd1);
        word = (nb == 2) ? {hi, lo} : {8'h00, hi};
        e_imm = (m == 2'd0) ? word : 16'h0;
        case (m)
            2'd1:    e_ea = {8'h00, hi};
            2'd2:    e_ea = word;
            2'd3:    e_ea = (s ? y : x) + {8'h00, hi};
            default: e_ea = 16'h0;
        endcase
        @(negedge clk);
        mode = m; wide = w; idx_sel = s; has_pre = p; next_pc = pc; ix = x; iy = y;
        stall_en = stl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ix = ~x; iy = ~y;                        // R7: index sampled at start
        if (poke) begin
            start = 1'b1; mode = ~m; wide = ~w; next_pc = ~pc;
        end
        beats = 0; n = 0;
        while (n < 50) begin
            if (n >= 1) start = 1'b0;
            if (done) break;
            if (rd_req && rd_ack) begin
                chk(rd_addr == pc + 16'(beats), {tag, " R3 addr"}, rd_addr, pc + 16'(beats));
                beats++;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(done, {tag, " R9 done"}, done, 1);
        chk(beats == nb, {tag, " R3 beats"}, beats, nb);
        if (!stl) chk(n == nb, {tag, " R9 latency"}, n, nb);
        chk(is_addr == (m != 2'd0), {tag, " R4 is_addr"}, is_addr, m != 2'd0);
        if (m == 2'd0) chk(imm_data == e_imm, {tag, " R4 imm"}, imm_data, e_imm);
        else chk(eff_addr == e_ea, {tag, " R5/R6/R7 ea"}, eff_addr, e_ea);
        chk(inst_len == 3'(1 + p + nb), {tag, " R8 len"}, inst_len, 1 + p + nb);
        stall_en = 1'b0;
    endtask

    task automatic t_reset;
        chk(!done && !rd_req, "R1 reset idle", {done, rd_req}, 0);
    endtask

    task automatic t_hold;
        logic [15:0] e0, i0;
        logic [2:0]  l0;
        e0 = eff_addr; i0 = imm_data; l0 = inst_len;
        repeat (3) @(negedge clk);
        chk(done && eff_addr == e0 && imm_data == i0 && inst_len == l0,
            "R9 hold", eff_addr, e0);
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        mode = 2'd2; next_pc = 16'h5000; stall_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; stall_en = 1'b0;
        chk(!done && !rd_req, "R1 reset mid-fetch", {done, rd_req}, 0);
        @(negedge clk);
        chk(!rd_req, "R1 stays idle", rd_req, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        run_op("imm8",    2'd0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0, 16'h0, 1'b0, 1'b0);
        run_op("imm16p",  2'd0, 1'b1, 1'b0, 1'b1, 16'h20FF, 16'h0, 16'h0, 1'b0, 1'b0);
        run_op("dir",     2'd1, 1'b0, 1'b0, 1'b0, 16'h4000, 16'h0, 16'h0, 1'b0, 1'b0);
        run_op("dirp",    2'd1, 1'b1, 1'b0, 1'b1, 16'h40F3, 16'h0, 16'h0, 1'b0, 1'b0);
        run_op("ext",     2'd2, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0, 16'h0, 1'b0, 1'b0);
        run_op("extp",    2'd2, 1'b0, 1'b0, 1'b1, 16'h7A10, 16'h0, 16'h0, 1'b0, 1'b0);
        run_op("idxX",    2'd3, 1'b0, 1'b0, 1'b0, 16'h0011, 16'hFFF0, 16'h1000, 1'b0, 1'b0);
        run_op("idxYp",   2'd3, 1'b0, 1'b1, 1'b1, 16'h00AA, 16'h0F00, 16'h2345, 1'b0, 1'b0);
        t_hold();
        run_op("extStall", 2'd2, 1'b0, 1'b0, 1'b0, 16'h3001, 16'h0, 16'h0, 1'b1, 1'b0);
        run_op("imm16Stall", 2'd0, 1'b1, 1'b0, 1'b0, 16'h8080, 16'h0, 16'h0, 1'b1, 1'b0);
        run_op("R2poke",  2'd2, 1'b0, 1'b0, 1'b0, 16'h6543, 16'h0, 16'h0, 1'b1, 1'b1);
        run_op("R2poke1", 2'd1, 1'b0, 1'b0, 1'b0, 16'h0102, 16'h0, 16'h0, 1'b0, 1'b1);
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule